// File: doc/BRIEF.md
# Predicated Vector Element Step Sequencer

This block walks the element positions of a vector operation whose source and destination are each guarded by their own predicate mask. It is given a vector length, a starting source step, a starting destination step, a source mask and a destination mask. The destination mask can optionally be taken as the bitwise complement of its input. On each cycle it searches forward from the current source step for the next enabled source element, and from the current destination step for the next enabled destination element. It presents the pair as one element operation, and it moves both steps one past the pair when the execution unit accepts it.

The steps can start at any saved value. This lets an operation that was stopped by an interrupt continue where it left off instead of starting again at element zero. Mask bits below the starting step are never looked at. The live step values are visible on every cycle so that an interrupt can capture them. When either search runs into the vector length, the block flags completion and clears both steps to zero. It produces only indices, a valid strobe and a completion flag. Register access and the element operation itself belong to the surrounding pipeline.

Top module: `vec_step_seq`

## Requirements
- R1: While reset is held and after it is released, with no start, valid, done and busy are 0 and both exposed steps are 0.
- R2: A start pulse latches the length, both steps, both masks and the invert select; on the next cycle busy is 1 and src_step/dst_step equal the supplied start steps.
- R3: src_idx is the lowest position at or above the current source step whose source mask bit is 1.
- R4: dst_idx is the lowest position at or above the current destination step whose destination mask bit is 1, searched independently of the source.
- R5: When dst_mask_inv is 1, the destination search uses the bitwise complement of dst_mask_in (for example 0101 gives 1010).
- R6: While valid is 1 and ready is 0, the pair is held: on the next cycle valid is still 1 and both indices are unchanged.
- R7: When a pair is accepted (valid and ready both 1), on the next cycle src_step is src_idx+1 and dst_step is dst_idx+1.
- R8: done is 1 for one cycle when either search finds no enabled element below the vector length; the cycle after that, busy is 0 and both steps are 0. Exactly the pairs below the length are issued.
- R9: Mask bits at positions below the starting step are ignored and are never issued.
- R10: With length 4, source step 1, source mask 0101, destination step 2 and inverted destination mask 0101, exactly one pair is issued: source 2 with destination 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Latch the loop parameters and begin |
| vec_len | input | SW | Vector length |
| src_step_in | input | SW | Starting source step |
| dst_step_in | input | SW | Starting destination step |
| src_mask | input | NE | Source predicate mask |
| dst_mask_in | input | NE | Destination predicate register value |
| dst_mask_inv | input | 1 | Use the complement of dst_mask_in |
| ready | input | 1 | Execution unit accepts the current pair |
| valid | output | 1 | A pair is presented |
| src_idx | output | SW | Source element index |
| dst_idx | output | SW | Destination element index |
| src_step | output | SW | Live source step |
| dst_step | output | SW | Live destination step |
| busy | output | 1 | Loop in progress |
| done | output | 1 | Loop finished this cycle |

## Verification
The start parameters reach src_step and dst_step one cycle after the start pulse. After that, valid, done and the indices follow in the same cycle as the registered steps, because the searches are combinational. An accepted pair shows up in the steps one edge later, and the clear that follows done also shows up one edge later. The bench drives its inputs on the falling edge and samples there. It compares each valid cycle with the next entry of a pair list that it computed itself, and it advances that list only on cycles where ready was high. A ready pattern with gaps exposes the hold behaviour.

// File: rtl/vec_step_seq.sv
module vec_step_seq #(
  parameter int SW = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SW-1:0]     vec_len,
  input  logic [SW-1:0]     src_step_in,
  input  logic [SW-1:0]     dst_step_in,
  input  logic [(1<<SW)-1:0] src_mask,
  input  logic [(1<<SW)-1:0] dst_mask_in,
  input  logic              dst_mask_inv,
  input  logic              ready,
  output logic              valid,
  output logic [SW-1:0]     src_idx,
  output logic [SW-1:0]     dst_idx,
  output logic [SW-1:0]     src_step,
  output logic [SW-1:0]     dst_step,
  output logic              busy,
  output logic              done
);
  localparam int NE = 1 << SW;
  localparam logic [SW:0] NONE = NE[SW:0];

  logic [SW:0]   s_q, d_q, s_pos, d_pos;
  logic [SW-1:0] len_q;
  logic [NE-1:0] sm_q, dm_q;
  logic          busy_q, found;

  function automatic logic [SW:0] first_set(input logic [NE-1:0] m, input logic [SW:0] from);
    first_set = NONE;
    for (int i = NE - 1; i >= 0; i--)
      if (m[i] && (SW+1)'(i) >= from) first_set = (SW+1)'(i);
  endfunction

  assign s_pos = first_set(sm_q, s_q);
  assign d_pos = first_set(dm_q, d_q);
  assign found = (s_pos < {1'b0, len_q}) && (d_pos < {1'b0, len_q});

  assign valid    = busy_q & found;
  assign done     = busy_q & ~found;
  assign busy     = busy_q;
  assign src_idx  = s_pos[SW-1:0];
  assign dst_idx  = d_pos[SW-1:0];
  assign src_step = s_q[SW-1:0];
  assign dst_step = d_q[SW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      s_q    <= '0;
      d_q    <= '0;
      len_q  <= '0;
      sm_q   <= '0;
      dm_q   <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      s_q    <= {1'b0, src_step_in};
      d_q    <= {1'b0, dst_step_in};
      len_q  <= vec_len;
      sm_q   <= src_mask;
      dm_q   <= dst_mask_inv ? ~dst_mask_in : dst_mask_in;
    end else if (busy_q) begin
      if (!found) begin
        busy_q <= 1'b0;
        s_q    <= '0;
        d_q    <= '0;
      end else if (ready) begin
        s_q <= s_pos + 1'b1;
        d_q <= d_pos + 1'b1;
      end
    end
  end

  // R1
  valid_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(valid && done));
  // R6
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready && !start) |=> (valid && $stable(src_idx) && $stable(dst_idx)));
  // R7
  monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && ready && !start) |=> (!valid || (src_idx > $past(src_idx) && dst_idx > $past(dst_idx))));
  // R8
  clear_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (!busy && src_step == '0 && dst_step == '0));
  // R9
  no_backward_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (src_idx >= src_step && dst_idx >= dst_step));
endmodule

// File: tb/vec_step_seq_test.sv
module vec_step_seq_test;
  localparam int SW = 3;
  localparam int NE = 1 << SW;

  logic clk = 0, rst_n = 0, start = 0, dst_mask_inv = 0, ready = 0;
  logic [SW-1:0] vec_len = 0, src_step_in = 0, dst_step_in = 0;
  logic [NE-1:0] src_mask = 0, dst_mask_in = 0;
  logic valid, busy, done;
  logic [SW-1:0] src_idx, dst_idx, src_step, dst_step;

  int total = 0, bad = 0, last_issued = 0;

  always #10 clk = ~clk;

  vec_step_seq #(.SW(SW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .vec_len(vec_len),
    .src_step_in(src_step_in), .dst_step_in(dst_step_in),
    .src_mask(src_mask), .dst_mask_in(dst_mask_in), .dst_mask_inv(dst_mask_inv),
    .ready(ready), .valid(valid), .src_idx(src_idx), .dst_idx(dst_idx),
    .src_step(src_step), .dst_step(dst_step), .busy(busy), .done(done));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(input int vl, input int ss, input int ds, input logic [NE-1:0] sm,
                     input logic [NE-1:0] dmr, input logic inv, input int rmode);
    int es[NE], ed[NE];
    int n = 0, s = ss, d = ds, ptr = 0;
    logic [NE-1:0] dm = inv ? ~dmr : dmr;
    bit finished = 0, stalled = 0, acc = 0;
    int st_s = 0, st_d = 0, pv_s = 0, pv_d = 0;
    string dreq = inv ? "R5" : "R4";
    forever begin
      while (s < vl && !sm[s]) s++;
      while (d < vl && !dm[d]) d++;
      if (s >= vl || d >= vl) break;
      es[n] = s; ed[n] = d; n++; s++; d++;
    end
    @(negedge clk);
    vec_len = SW'(vl); src_step_in = SW'(ss); dst_step_in = SW'(ds);
    src_mask = sm; dst_mask_in = dmr; dst_mask_inv = inv; start = 1; ready = 0;
    @(negedge clk);
    start = 0;
    chk(busy && src_step == SW'(ss) && dst_step == SW'(ds), "R2 start latch", int'(src_step), ss);
    last_issued = 0;
    for (int c = 0; c < 40 && !finished; c++) begin
      bit rdy = ((c + rmode) % 3) != 0;
      ready = rdy;
      #1;
      if (acc) begin
        chk(int'(src_step) == pv_s + 1, "R7 src step advance", int'(src_step), pv_s + 1);
        chk(int'(dst_step) == pv_d + 1, "R7 dst step advance", int'(dst_step), pv_d + 1);
      end
      if (stalled)
        chk(valid && int'(src_idx) == st_s && int'(dst_idx) == st_d, "R6 hold", int'(src_idx), st_s);
      acc = 0; stalled = 0;
      if (valid) begin
        if (ptr >= n) chk(0, "R8 extra pair", ptr + 1, n);
        else begin
          chk(int'(src_idx) == es[ptr], "R3 src index", int'(src_idx), es[ptr]);
          chk(int'(dst_idx) == ed[ptr], dreq, int'(dst_idx), ed[ptr]);
        end
        if (rdy) begin
          ptr++; last_issued++; acc = 1; pv_s = int'(src_idx); pv_d = int'(dst_idx);
        end else begin
          stalled = 1; st_s = int'(src_idx); st_d = int'(dst_idx);
        end
      end
      if (done) begin
        chk(ptr == n, "R8 pair count", ptr, n);
        finished = 1;
      end
      @(negedge clk);
    end
    ready = 0;
    chk(finished, "R8 loop timeout", 0, 1);
    chk(!busy && !done && src_step == 0 && dst_step == 0, "R8 clear after done", int'(src_step), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(!valid && !done && !busy && src_step == 0 && dst_step == 0, "R1 in reset", int'(valid), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(!valid && !done && !busy && src_step == 0 && dst_step == 0, "R1 idle", int'(busy), 0);

    // R10 worked example
    run(4, 1, 2, 8'b0000_0101, 8'b0000_0101, 1'b1, 0);
    chk(last_issued == 1, "R10 pair count", last_issued, 1);

    // R9 bits below start step ignored
    run(7, 5, 3, 8'hFF, 8'hFF, 1'b0, 1);
    chk(last_issued == 2, "R9 start-step skip", last_issued, 2);

    for (int vl = 0; vl < NE; vl++)
      for (int si = 0; si < 4; si++)
        for (int di = 0; di < 3; di++)
          for (int inv = 0; inv < 2; inv++)
            for (int k = 0; k < 10; k++) begin
              logic [NE-1:0] sm, dm;
              int ss = (si == 3) ? 6 : si * 1 + (si == 2 ? 1 : 0);
              int ds = di == 0 ? 0 : (di == 1 ? 2 : 5);
              sm = (k == 8) ? 8'hFF : (k == 9) ? 8'h00 : NE'(k * 37 + 5);
              dm = (k == 8) ? 8'h00 : (k == 9) ? 8'hFF : NE'(k * 91 + 3);
              run(vl, ss, ds, sm, dm, inv[0], k);
            end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule